// File: doc/BRIEF.md
# Read Leveling Training Sequencer

This block calibrates the read capture delay of every byte lane of a double-data-rate memory interface. It does this without writing to memory and without extra calibration pins. When `start` is pulsed, it first requests a mode register write. That write makes the memory return a fixed training pattern, in place of array data, on its data, mask and strobe pins. The sequencer then issues one read burst per delay tap, sweeping the tap from the smallest value to the largest. For each lane it records whether the burst captured at that tap matched the pattern.

Every lane keeps a running record of the longest unbroken stretch of passing taps. Once the sweep ends, the sequencer requests a second mode register write that restores normal array reads. It then latches, for each lane, the tap at the centre of that stretch. The capture logic applies this value inside the controller. A lane that never passed is flagged.

The states are IDLE, MR_ON (pattern-enable write pending), RD_REQ (read request pending), RD_WAIT (collecting the burst), EVAL (record the verdict, advance the tap), MR_OFF (pattern-disable write pending) and DONE. The transitions are:
- IDLE→MR_ON and DONE→MR_ON on `start`.
- MR_ON→RD_REQ and RD_REQ→RD_WAIT when the command is accepted.
- RD_WAIT→EVAL on the last beat.
- EVAL→RD_REQ while the tap is below its maximum, and EVAL→MR_OFF at the maximum.
- MR_OFF→DONE when the command is accepted.

Top module: `rdlvl_train`

## Requirements
- R1: After reset, `cmd_valid`, `done`, every `lane_err` bit and every lane delay are 0.
- R2: The first command after `start` is the pattern-enable mode write, `cmd_op` = 2'b01.
- R3: Exactly 2^TAP_W read commands (`cmd_op` = 2'b11) follow. While the k-th read (counting from 0) is offered, every lane's delay output equals k.
- R4: A burst passes for a lane only if all BURST beats match. The expected value is all zeros on even beats (0, 2, 4, 6) and all ones on odd beats. A single wrong bit in a single beat fails the tap.
- R5: A lane's result is start + (length−1)/2, rounded down, of its longest run of consecutive passing taps. When runs tie, the run with the lowest start wins.
- R6: A lane with no passing tap gets its `lane_err` bit set and a delay of 0.
- R7: After the last burst, the pattern-disable mode write (`cmd_op` = 2'b10) is issued. Only after it is accepted does `done` rise. `done` then stays high, with no further commands and steady delays, until the next `start`.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and `cmd_op` hold their values.
- R9: `start` in the done state reruns the whole sequence, and error bits from the previous run are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a training run (accepted in IDLE or DONE) |
| cmd_valid | output | 1 | Command request valid |
| cmd_op | output | 2 | 01 pattern-enable mode write, 10 pattern-disable mode write, 11 read burst |
| cmd_ready | input | 1 | Command accepted when high with `cmd_valid` |
| rd_valid | input | 1 | One captured beat present on `rd_data` |
| rd_data | input | LANES*DQ_W | Captured beat, lane i in bits [i*DQ_W +: DQ_W] |
| rd_delay | output | LANES*TAP_W | Capture delay per lane: the sweep tap while training, then the result |
| done | output | 1 | Training complete, results valid |
| lane_err | output | LANES | Lane found no passing tap |

## Verification
The hardest outcomes to reach from the ports are ties between equally long passing runs, a window that touches tap 0 or the top tap, and a lane that never passes. The bench's memory responder addresses all three. It reads the tap it is being probed at from the delay port, and it looks up a per-lane pass mask chosen for that case. For a failing tap it corrupts exactly one bit of one beat. This makes it possible to build two-run ties, single-tap windows at both ends, empty masks and full masks. It also makes every fail verdict depend on the whole burst being compared. A stalling `cmd_ready` pattern exercises command hold.

// File: rtl/rdlvl_pkg.sv
package rdlvl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MR_ON,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_EVAL,
        ST_MR_OFF,
        ST_DONE
    } rl_state_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_MR_ON  = 2'b01,
        OP_MR_OFF = 2'b10,
        OP_READ   = 2'b11
    } rl_op_e;
endpackage

// File: rtl/rdlvl_beat_check.sv
// Accumulates a mismatch flag over one burst for one lane (R4).
module rdlvl_beat_check #(
    parameter int DQ_W   = 8,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic [DQ_W-1:0]   data,
    output logic              pass
);
    logic              bad;
    logic [DQ_W-1:0]   expect_word;

    // even beats all zeros, odd beats all ones
    assign expect_word = {DQ_W{beat_idx[0]}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad <= 1'b0;
        end else if (clear) begin
            bad <= 1'b0;
        end else if (beat_valid && (data != expect_word)) begin
            bad <= 1'b1;
        end
    end

    assign pass = !bad;
endmodule

// File: rtl/rdlvl_window.sv
// Tracks the longest run of passing taps and its centre (R5, R6).
module rdlvl_window #(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic [TAP_W-1:0] tap,
    input  logic             pass,
    output logic             found,
    output logic [TAP_W-1:0] centre
);
    logic [TAP_W-1:0] cur_start, best_start, run_start;
    logic [TAP_W:0]   cur_len, best_len, run_len, span;

    assign run_start = (cur_len == '0) ? tap : cur_start;
    assign run_len   = cur_len + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_start  <= '0;
            cur_len    <= '0;
            best_start <= '0;
            best_len   <= '0;
        end else if (clear) begin
            cur_start  <= '0;
            cur_len    <= '0;
            best_start <= '0;
            best_len   <= '0;
        end else if (sample) begin
            if (pass) begin
                cur_start <= run_start;
                cur_len   <= run_len;
                // strictly longer: an earlier equal run is kept
                if (run_len > best_len) begin
                    best_start <= run_start;
                    best_len   <= run_len;
                end
            end else begin
                cur_len <= '0;
            end
        end
    end

    assign found  = (best_len != '0);
    assign span   = best_len - 1'b1;
    assign centre = found ? (best_start + span[TAP_W:1]) : '0;
endmodule

// File: rtl/rdlvl_train.sv
module rdlvl_train
    import rdlvl_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DQ_W  = 8,
    parameter int TAP_W = 5,
    parameter int BURST = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   cmd_valid,
    output logic [1:0]             cmd_op,
    input  logic                   cmd_ready,
    input  logic                   rd_valid,
    input  logic [LANES*DQ_W-1:0]  rd_data,
    output logic [LANES*TAP_W-1:0] rd_delay,
    output logic                   done,
    output logic [LANES-1:0]       lane_err
);
    localparam int               BEAT_W   = (BURST > 1) ? $clog2(BURST) : 1;
    localparam logic [TAP_W-1:0] TAP_MAX  = {TAP_W{1'b1}};
    localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST - 1);

    rl_state_e        state, state_nx;
    logic [TAP_W-1:0] tap;
    logic [BEAT_W-1:0] beat;
    logic             launch, sweeping;

    assign launch = start && ((state == ST_IDLE) || (state == ST_DONE));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_MR_ON;
            ST_MR_ON:   if (cmd_ready) state_nx = ST_RD_REQ;
            ST_RD_REQ:  if (cmd_ready) state_nx = ST_RD_WAIT;
            ST_RD_WAIT: if (rd_valid && (beat == BEAT_LAST)) state_nx = ST_EVAL;
            ST_EVAL:    state_nx = (tap == TAP_MAX) ? ST_MR_OFF : ST_RD_REQ;
            ST_MR_OFF:  if (cmd_ready) state_nx = ST_DONE;
            ST_DONE:    if (start) state_nx = ST_MR_ON;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_NONE;
        sweeping  = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_MR_ON:   begin cmd_valid = 1'b1; cmd_op = OP_MR_ON; sweeping = 1'b1; end
            ST_RD_REQ:  begin cmd_valid = 1'b1; cmd_op = OP_READ;  sweeping = 1'b1; end
            ST_RD_WAIT: sweeping = 1'b1;
            ST_EVAL:    sweeping = 1'b1;
            ST_MR_OFF:  begin cmd_valid = 1'b1; cmd_op = OP_MR_OFF; end
            ST_DONE:    done = 1'b1;
            default:    ;
        endcase
    end

    // tap and beat counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap  <= '0;
            beat <= '0;
        end else begin
            if (launch) tap <= '0;
            else if ((state == ST_EVAL) && (tap != TAP_MAX)) tap <= tap + 1'b1;

            if (state == ST_RD_REQ) beat <= '0;
            else if ((state == ST_RD_WAIT) && rd_valid) beat <= beat + 1'b1;
        end
    end

    // per-lane judge, window and result
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic             pass, found;
        logic [TAP_W-1:0] centre, res;
        logic             err;

        rdlvl_beat_check #(.DQ_W(DQ_W), .BEAT_W(BEAT_W)) u_chk (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (state == ST_RD_REQ),
            .beat_valid((state == ST_RD_WAIT) && rd_valid),
            .beat_idx  (beat),
            .data      (rd_data[g*DQ_W +: DQ_W]),
            .pass      (pass)
        );

        rdlvl_window #(.TAP_W(TAP_W)) u_win (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (launch),
            .sample(state == ST_EVAL),
            .tap   (tap),
            .pass  (pass),
            .found (found),
            .centre(centre)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res <= '0;
                err <= 1'b0;
            end else if (launch) begin
                res <= '0;
                err <= 1'b0;
            end else if (state == ST_MR_OFF) begin
                res <= centre;
                err <= !found;
            end
        end

        assign rd_delay[g*TAP_W +: TAP_W] = sweeping ? tap : res;
        assign lane_err[g]                = err;
    end
endmodule

// File: rtl/rdlvl_train_chk.sv
module rdlvl_train_chk #(
    parameter int LANES = 2,
    parameter int TAP_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic [1:0]             cmd_op,
    input logic                   cmd_ready,
    input logic [LANES*TAP_W-1:0] rd_delay,
    input logic                   done,
    input logic [LANES-1:0]       lane_err
);
    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op)));

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid);

    assert_done_after_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cmd_valid && cmd_ready && (cmd_op == 2'b10)));

    assert_done_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(rd_delay));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assert_read_tap_shared_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && (cmd_op == 2'b11)) |->
            (rd_delay[g*TAP_W +: TAP_W] == rd_delay[0 +: TAP_W]));

        assert_err_zero_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (done && lane_err[g]) |-> (rd_delay[g*TAP_W +: TAP_W] == '0));
    end
endmodule

bind rdlvl_train rdlvl_train_chk #(.LANES(LANES), .TAP_W(TAP_W)) u_rdlvl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_ready(cmd_ready),
    .rd_delay (rd_delay),
    .done     (done),
    .lane_err (lane_err)
);

// File: tb/test_rdlvl_train.sv
`timescale 1ns/1ps
module test_rdlvl_train;
    localparam int LANES = 2;
    localparam int DQ_W  = 8;
    localparam int TAP_W = 5;
    localparam int BURST = 8;
    localparam int NT    = 1 << TAP_W;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic                   cmd_valid;
    logic [1:0]             cmd_op;
    logic                   cmd_ready = 1'b0;
    logic                   rd_valid = 1'b0;
    logic [LANES*DQ_W-1:0]  rd_data = '0;
    logic [LANES*TAP_W-1:0] rd_delay;
    logic                   done;
    logic [LANES-1:0]       lane_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_idx = 0;
    bit stall = 1'b0;
    bit prev_wait = 1'b0;
    logic [1:0] prev_op = 2'b00;
    logic [NT-1:0] win_mask [LANES];
    logic [1:0] exp_q [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    rdlvl_train #(.LANES(LANES), .DQ_W(DQ_W), .TAP_W(TAP_W), .BURST(BURST)) i_rdlvl_train (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_delay(rd_delay), .done(done), .lane_err(lane_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [NT-1:0] span_mask(input int lo, input int hi);
        logic [NT-1:0] m = '0;
        for (int t = lo; t <= hi; t++) m[t] = 1'b1;
        return m;
    endfunction

    // expected centre of longest run, lowest start on ties
    function automatic void expect_lane(input logic [NT-1:0] m, output int d, output bit e);
        int bs = 0, bl = 0, cs = 0, cl = 0;
        for (int t = 0; t < NT; t++) begin
            if (m[t]) begin
                if (cl == 0) cs = t;
                cl++;
                if (cl > bl) begin bl = cl; bs = cs; end
            end else begin
                cl = 0;
            end
        end
        e = (bl == 0);
        d = e ? 0 : bs + (bl - 1) / 2;
    endfunction

    // monitor and memory responder
    initial begin
        forever begin
            @(negedge clk);
            cmd_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            #1;
            if (prev_wait) begin
                check(cmd_valid && (cmd_op == prev_op), "R8 hold", int'(cmd_op), int'(prev_op));
            end
            prev_wait = cmd_valid && !cmd_ready;
            prev_op   = cmd_op;
            if (cmd_valid && cmd_ready) begin
                prev_wait = 1'b0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected command", int'(cmd_op), 0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    check(cmd_op == e,
                          (e == 2'b01) ? "R2 op" : (e == 2'b11) ? "R3 op" : "R7 op",
                          int'(cmd_op), int'(e));
                end
                if (cmd_op == 2'b11) begin
                    int k;
                    k = rd_idx;
                    for (int l = 0; l < LANES; l++)
                        check(int'(rd_delay[l*TAP_W +: TAP_W]) == k, "R3 sweep tap",
                              int'(rd_delay[l*TAP_W +: TAP_W]), k);
                    rd_idx++;
                    @(negedge clk);
                    @(negedge clk);
                    for (int b = 0; b < BURST; b++) begin
                        for (int l = 0; l < LANES; l++) begin
                            logic [DQ_W-1:0] v;
                            v = (b % 2 == 1) ? {DQ_W{1'b1}} : '0;
                            // failing tap: one bit of one beat wrong (R4)
                            if (!win_mask[l][k] && (b == k % BURST)) v = v ^ (DQ_W'(1) << (k % DQ_W));
                            rd_data[l*DQ_W +: DQ_W] = v;
                        end
                        rd_valid = 1'b1;
                        @(negedge clk);
                    end
                    rd_valid = 1'b0;
                    rd_data  = '0;
                end
            end
        end
    end

    task automatic run_case(input logic [NT-1:0] m0, input logic [NT-1:0] m1,
                            input bit stall_on, input string name);
        int  d [LANES];
        bit  e [LANES];
        logic [LANES*TAP_W-1:0] held;
        win_mask[0] = m0;
        win_mask[1] = m1;
        for (int l = 0; l < LANES; l++) expect_lane(win_mask[l], d[l], e[l]);
        // driver pushes expected command stream
        exp_q.push_back(2'b01);
        for (int t = 0; t < NT; t++) exp_q.push_back(2'b11);
        exp_q.push_back(2'b10);
        rd_idx = 0;
        stall  = stall_on;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int w = 0; w < 20000 && !done; w++) @(negedge clk);
        #1;
        $display("case %s", name);
        check(done, "R7 done", int'(done), 1);
        check(exp_q.size() == 0, "R3 read count", exp_q.size(), 0);
        for (int l = 0; l < LANES; l++) begin
            check(int'(rd_delay[l*TAP_W +: TAP_W]) == d[l], "R4/R5 delay",
                  int'(rd_delay[l*TAP_W +: TAP_W]), d[l]);
            check(lane_err[l] == e[l], "R6/R9 lane_err", int'(lane_err[l]), int'(e[l]));
        end
        held = rd_delay;
        repeat (3) @(negedge clk);
        #1;
        check(done && !cmd_valid, "R7 done held quiet", int'(done), 1);
        check(rd_delay == held, "R7 delays steady", int'(rd_delay), int'(held));
        exp_q.delete();
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        win_mask[0] = '0;
        win_mask[1] = '0;
        repeat (3) @(negedge clk);
        #1;
        check(!cmd_valid && !done, "R1 reset idle", int'({cmd_valid, done}), 0);
        check(rd_delay == '0, "R1 reset delay", int'(rd_delay), 0);
        check(lane_err == '0, "R1 reset err", int'(lane_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!cmd_valid && !done && rd_delay == '0, "R1 after release", int'(cmd_valid), 0);

        // R5: single window; longest of two windows
        run_case(span_mask(10, 20), span_mask(3, 6) | span_mask(20, 28), 1'b0, "windows");
        // R6: no pass; full pass; stalled ready for R8
        run_case('0, '1, 1'b1, "empty_full");
        // R9 rerun clears error; R5 tie keeps lowest; single tap at top
        run_case(span_mask(2, 5) | span_mask(9, 12), span_mask(31, 31), 1'b0, "tie_top");
        // R4 single tap at zero; two-tap run at bottom
        run_case(span_mask(0, 0), span_mask(0, 1), 1'b1, "bottom");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule